// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects interrupt requests for a small 16-bit processor and decides which one the CPU should take next. There are seven sources. Three are internal: one request line shared by the timers, and two DMA channels. Four are external, active-high input pins. Every source has a control word with a 3-bit priority and a mask bit. The external pins can also choose edge or level triggering. The controller keeps a pending state and an in-service state for each source. It raises a single request line towards the CPU, and on acknowledge it latches the 5-bit vector type of the winning source.

Software reaches the block through a simple synchronous register bus. The control words, a shared mask view and a write-only end-of-interrupt command register all sit on that bus. The end-of-interrupt command can clear one named in-service bit (specific) or the highest-priority one (nonspecific). The first two external control words carry two mode bits. If either mode bit is set, the last two external pins are shut off. No further cascade handshaking is built.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no source is pending or in service. `irq_o` and `vec_o` are 0. Every control word reads 0x000F (priority 7, masked, edge trigger, mode bits clear). The mask view reads 0x007F.
- R2: Register addresses are: 0 timer word, 1 DMA0 word, 2 DMA1 word, 3 to 6 external pins 0 to 3, 7 mask view, 8 end-of-interrupt. In a control word, bits 2:0 are the priority (0 highest, 7 lowest) and bit 3 is the mask (1 = masked). External words add bit 4, the level-trigger select (1 = level). The words at addresses 3 and 4 add bit 5 (cascade) and bit 6 (special nested). All other bits read 0.
- R3: Bit i of the mask view (i = 0 timer, 1 DMA0, 2 DMA1, 3 to 6 external 0 to 3) is the same storage as bit 3 of control word i. A write to either location changes both.
- R4: A timer or DMA request that is high at a clock edge sets that source's pending bit. The bit stays set until the source is acknowledged. While the source is masked it is held but never forwarded.
- R5: Among forwardable sources, the one with the lowest priority value wins. On equal values, the lower vector type wins.
- R6: `irq_o` is high only when the winner's priority value is strictly lower than that of every source in service.
- R7: An external pin in level mode requests whenever it is high, including again after its in-service bit is cleared.
- R8: An external pin in edge mode requests only after a low-to-high change. It makes no new request after acknowledge until a fresh rising edge. If the pin falls before acknowledge, the request is lost.
- R9: `ack_i` while `irq_o` is high sets the winner's in-service bit and clears its pending state. On the next cycle `vec_o` shows its type: timer 8, DMA0 10, DMA1 11, external 0 to 3 types 12 to 15.
- R10: Writing address 8 with bit 15 = 0 is a specific command. It clears the in-service bit of the source whose type is in bits 4:0. Any type not in the R9 list does nothing.
- R11: Writing address 8 with bit 15 = 1 clears the in-service bit of the in-service source with the lowest priority value, with ties going to the lower type.
- R12: While bit 5 or bit 6 is set in the word at address 3 or 4, external pins 2 and 3 raise no request.
- R13: Address 8 is write-only and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_req_i | input | 1 | Shared timer request |
| dma_req_i | input | 2 | DMA channel requests (bit 0 = DMA0) |
| ext_i | input | 4 | External active-high interrupt pins |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data (combinational on address) |
| irq_o | output | 1 | Interrupt request to the CPU |
| ack_i | input | 1 | CPU acknowledge |
| vec_o | output | 5 | Vector type latched at acknowledge |

## Verification
The bench targets the equal-priority cases. A controller that compared with less-or-equal against the in-service level would let a same-level source nest. One that broke ties by higher type would return 11 instead of 10. It checks that a nonspecific end-of-interrupt clears the highest-priority in-service source and not some other one; clearing the wrong bit leaves a later specific command unable to release the blocked request. It drives edge-mode pins held high past acknowledge and dropped before acknowledge: a design that re-arms on level, or keeps a stale latched edge, raises `irq_o` where it must stay low. It also writes the mask through both views and sets the mode bits one at a time. Broken aliasing, or missing gating of pins 2 and 3, shows up in readback or on `irq_o`.

// File: rtl/pic_pkg.sv
// Shared constants and helpers for the priority interrupt controller.
// Assumes source order: timer, DMA channels, external pins.
package pic_pkg;
    localparam int NDMA     = 2;
    localparam int NEXT     = 4;
    localparam int NINT     = 1 + NDMA;          // internal sources
    localparam int NSRC     = NINT + NEXT;
    localparam int NCAS     = 2;                 // external words with mode bits
    localparam int PW       = 3;                 // priority width
    localparam int TW       = 5;                 // vector type width
    localparam int AW       = 4;
    localparam int DW       = 16;
    localparam int SIW      = $clog2(NSRC);
    localparam int MASK_BIT = PW;
    localparam int LTM_BIT  = PW + 1;
    localparam int CAS_BIT  = PW + 2;
    localparam int SFN_BIT  = PW + 3;
    localparam int EOI_NS_BIT = DW - 1;
    localparam int ADDR_MASK  = NSRC;
    localparam int ADDR_EOI   = NSRC + 1;
    localparam int TYPE_TMR   = 8;

    // Vector type of source index: timer 8, others 10 upward.
    function automatic logic [TW-1:0] src_type(input logic [SIW-1:0] idx);
        if (idx == '0) return TW'(TYPE_TMR);
        return TW'(idx) + TW'(TYPE_TMR + 1);
    endfunction
endpackage

// File: rtl/pic_trig.sv
// Trigger stage for one external pin: level or edge detection.
// Assumes the pin is already synchronous to clk. In edge mode a request
// exists from the rising edge until acknowledge or until the pin falls.
module pic_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic level_i,
    input  logic enable_i,
    input  logic ack_i,
    output logic req_o
);
    logic prev_q;
    logic armed_q;
    logic rise;

    assign rise = line_i & ~prev_q;

    // Track previous pin value and the armed edge state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b1;
            armed_q <= 1'b0;
        end else begin
            prev_q <= line_i;
            if (ack_i || !line_i)
                armed_q <= 1'b0;
            else if (rise)
                armed_q <= 1'b1;
        end
    end

    // Request: live level, or an edge still held high.
    always_comb begin
        if (level_i)
            req_o = enable_i & line_i;
        else
            req_o = enable_i & line_i & (armed_q | rise);
    end
endmodule

// File: rtl/pic_pick.sv
// Finds the valid entry with the lowest priority value; ties go to the
// lowest index. Pure combinational, N small.
module pic_pick #(
    parameter int N  = 7,
    parameter int PW = 3,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]    valid_i,
    input  logic [N*PW-1:0] prio_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o,
    output logic [PW-1:0]   prio_o
);
    // Linear scan keeps the earlier index on equal priority.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '1;
        for (int i = 0; i < N; i++) begin
            if (valid_i[i] && (!found_o || prio_i[i*PW +: PW] < prio_o)) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
                prio_o  = prio_i[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/pic_regs.sv
// Register file: control words, aliased mask view, end-of-interrupt decode.
// Assumes one write per cycle; reads are combinational on the address.
module pic_regs
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic [NSRC*PW-1:0] prio_o,
    output logic [NSRC-1:0]  mask_o,
    output logic [NEXT-1:0]  ltm_o,
    output logic             hi_dis_o,
    output logic             eoi_we_o,
    output logic             eoi_ns_o,
    output logic [TW-1:0]    eoi_type_o
);
    logic [PW-1:0]   prio_q [NSRC];
    logic [NSRC-1:0] mask_q;
    logic [NEXT-1:0] ltm_q;
    logic [NCAS-1:0] cas_q;
    logic [NCAS-1:0] sfn_q;
    logic            wdata_spare_unused;

    assign wdata_spare_unused = ^wdata_i[EOI_NS_BIT-1:SFN_BIT+1];

    // Write path: one storage bit per mask, reachable from two addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) prio_q[i] <= '1;
            mask_q <= '1;
            ltm_q  <= '0;
            cas_q  <= '0;
            sfn_q  <= '0;
        end else if (wr_en_i) begin
            for (int i = 0; i < NSRC; i++) begin
                if (addr_i == AW'(i)) begin
                    prio_q[i] <= wdata_i[PW-1:0];
                    mask_q[i] <= wdata_i[MASK_BIT];
                end
            end
            for (int j = 0; j < NEXT; j++)
                if (addr_i == AW'(NINT + j)) ltm_q[j] <= wdata_i[LTM_BIT];
            for (int j = 0; j < NCAS; j++) begin
                if (addr_i == AW'(NINT + j)) begin
                    cas_q[j] <= wdata_i[CAS_BIT];
                    sfn_q[j] <= wdata_i[SFN_BIT];
                end
            end
            if (addr_i == AW'(ADDR_MASK)) mask_q <= wdata_i[NSRC-1:0];
        end
    end

    // Read path: unused bits and the command register return zero.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (addr_i == AW'(i)) begin
                rdata_o[PW-1:0]    = prio_q[i];
                rdata_o[MASK_BIT]  = mask_q[i];
            end
        end
        for (int j = 0; j < NEXT; j++)
            if (addr_i == AW'(NINT + j)) rdata_o[LTM_BIT] = ltm_q[j];
        for (int j = 0; j < NCAS; j++) begin
            if (addr_i == AW'(NINT + j)) begin
                rdata_o[CAS_BIT] = cas_q[j];
                rdata_o[SFN_BIT] = sfn_q[j];
            end
        end
        if (addr_i == AW'(ADDR_MASK)) rdata_o[NSRC-1:0] = mask_q;
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_prio
            assign prio_o[g*PW +: PW] = prio_q[g];
        end
    endgenerate

    assign mask_o     = mask_q;
    assign ltm_o      = ltm_q;
    assign hi_dis_o   = |cas_q | |sfn_q;
    assign eoi_we_o   = wr_en_i && (addr_i == AW'(ADDR_EOI));
    assign eoi_ns_o   = wdata_i[EOI_NS_BIT];
    assign eoi_type_o = wdata_i[TW-1:0];
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: pending and in-service tracking, arbitration against the in-service
// level, acknowledge and end-of-interrupt handling.
// Assumes all inputs synchronous to clk and ack_i is a single-cycle pulse.
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tmr_req_i,
    input  logic [NDMA-1:0] dma_req_i,
    input  logic [NEXT-1:0] ext_i,
    input  logic            bus_we_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [DW-1:0]   bus_wdata_i,
    output logic [DW-1:0]   bus_rdata_o,
    output logic            irq_o,
    input  logic            ack_i,
    output logic [TW-1:0]   vec_o
);
    logic [NSRC*PW-1:0] prio;
    logic [NSRC-1:0]    mask_q;
    logic [NEXT-1:0]    ltm;
    logic               hi_dis;
    logic               eoi_we;
    logic               eoi_ns;
    logic [TW-1:0]      eoi_type;

    logic [NINT-1:0]    int_pend_q;
    logic [NEXT-1:0]    ext_req;
    logic [NSRC-1:0]    src_req;
    logic [NSRC-1:0]    isr_q;
    logic [NSRC-1:0]    eoi_clr;
    logic [NSRC-1:0]    ack_sel;
    logic [TW-1:0]      vec_q;

    logic               win_found;
    logic [SIW-1:0]     win_idx;
    logic [PW-1:0]      win_prio;
    logic [TW-1:0]      win_type;
    logic               isr_found;
    logic [SIW-1:0]     isr_idx;
    logic [PW-1:0]      isr_prio;
    logic [PW:0]        isr_level;
    logic               ack_take;

    pic_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (bus_we_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (bus_rdata_o),
        .prio_o     (prio),
        .mask_o     (mask_q),
        .ltm_o      (ltm),
        .hi_dis_o   (hi_dis),
        .eoi_we_o   (eoi_we),
        .eoi_ns_o   (eoi_ns),
        .eoi_type_o (eoi_type)
    );

    // One trigger stage per external pin; upper pins gated by mode bits.
    generate
        for (genvar g = 0; g < NEXT; g++) begin : g_ext
            logic pin_en;
            if (g < NCAS) begin : g_always
                assign pin_en = 1'b1;
            end else begin : g_gated
                assign pin_en = ~hi_dis;
            end
            pic_trig u_trig (
                .clk      (clk),
                .rst_n    (rst_n),
                .line_i   (ext_i[g]),
                .level_i  (ltm[g]),
                .enable_i (pin_en),
                .ack_i    (ack_sel[NINT+g]),
                .req_o    (ext_req[g])
            );
        end
    endgenerate

    assign src_req = {ext_req, int_pend_q};

    pic_pick #(.N(NSRC), .PW(PW), .IW(SIW)) u_win (
        .valid_i (src_req & ~mask_q),
        .prio_i  (prio),
        .found_o (win_found),
        .idx_o   (win_idx),
        .prio_o  (win_prio)
    );

    pic_pick #(.N(NSRC), .PW(PW), .IW(SIW)) u_isr (
        .valid_i (isr_q),
        .prio_i  (prio),
        .found_o (isr_found),
        .idx_o   (isr_idx),
        .prio_o  (isr_prio)
    );

    // In-service level; one above the lowest priority when nothing is active.
    assign isr_level = isr_found ? {1'b0, isr_prio} : {1'b1, {PW{1'b0}}};
    assign irq_o     = win_found && ({1'b0, win_prio} < isr_level);
    assign win_type  = src_type(win_idx);
    assign ack_take  = ack_i & irq_o;
    assign ack_sel   = ack_take ? (NSRC'(1) << win_idx) : '0;

    // Decode which in-service bit an end-of-interrupt command clears.
    always_comb begin
        eoi_clr = '0;
        if (eoi_we) begin
            if (eoi_ns) begin
                if (isr_found) eoi_clr[isr_idx] = 1'b1;
            end else begin
                for (int i = 0; i < NSRC; i++)
                    if (eoi_type == src_type(SIW'(i))) eoi_clr[i] = 1'b1;
            end
        end
    end

    // Pending, in-service and vector state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_pend_q <= '0;
            isr_q      <= '0;
            vec_q      <= '0;
        end else begin
            int_pend_q <= (int_pend_q & ~ack_sel[NINT-1:0]) | {dma_req_i, tmr_req_i};
            isr_q      <= (isr_q & ~eoi_clr) | ack_sel;
            if (ack_take) vec_q <= win_type;
        end
    end

    assign vec_o = vec_q;
endmodule

// File: rtl/pic_chk.sv
// Property checker for prio_irq_ctrl, attached with bind below.
// Assumes the source order and vector types of pic_pkg.
module pic_chk
    import pic_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            ack_i,
    input logic            irq_o,
    input logic [TW-1:0]   vec_o,
    input logic [TW-1:0]   win_type,
    input logic [SIW-1:0]  win_idx,
    input logic [NSRC-1:0] mask_q,
    input logic [NSRC-1:0] isr_q,
    input logic            eoi_we,
    input logic            eoi_ns,
    input logic [TW-1:0]   eoi_type,
    input logic            hi_dis,
    input logic [NEXT-1:0] ext_req,
    input logic [AW-1:0]   bus_addr_i,
    input logic [DW-1:0]   bus_rdata_o
);
    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !mask_q[win_idx]);

    p_no_renest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !isr_q[win_idx]);

    p_ack_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (vec_o == $past(win_type)) && isr_q[$past(win_idx)]);

    // R10: specific command for type 10 (DMA0, index 1) clears its bit.
    p_spec_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we && !eoi_ns && eoi_type == TW'(10) && !(ack_i && irq_o))
        |=> !isr_q[1]);

    p_ns_eoi_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we && eoi_ns && isr_q != '0 && !(ack_i && irq_o))
        |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

    p_hi_pins_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hi_dis |-> ext_req[NEXT-1:NCAS] == '0);

    p_eoi_reads_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == AW'(ADDR_EOI)) |-> bus_rdata_o == '0);
endmodule

bind prio_irq_ctrl pic_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .irq_o       (irq_o),
    .vec_o       (vec_o),
    .win_type    (win_type),
    .win_idx     (win_idx),
    .mask_q      (mask_q),
    .isr_q       (isr_q),
    .eoi_we      (eoi_we),
    .eoi_ns      (eoi_ns),
    .eoi_type    (eoi_type),
    .hi_dis      (hi_dis),
    .ext_req     (ext_req),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
// Bench for prio_irq_ctrl: table of register write/readback vectors,
// then directed tests for arbitration, triggering and end-of-interrupt.
module sim_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_req_i = 1'b0;
    logic [1:0]  dma_req_i = '0;
    logic [3:0]  ext_i = '0;
    logic        bus_we_i = 1'b0;
    logic [3:0]  bus_addr_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic        irq_o;
    logic        ack_i = 1'b0;
    logic [4:0]  vec_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prio_irq_ctrl u0 (.*);

    // {write addr, write data, read addr, expected read}
    localparam logic [39:0] TBL [8] = '{
        {4'd0, 16'hFFF2, 4'd0, 16'h0002},   // R2 upper bits dropped
        {4'd0, 16'h0000, 4'd7, 16'h007E},   // R3 word write seen in mask view
        {4'd7, 16'h0041, 4'd0, 16'h0008},   // R3 mask view seen in word
        {4'd3, 16'hFFFF, 4'd3, 16'h007F},   // R2 ext0 has mode bits
        {4'd5, 16'hFFFF, 4'd5, 16'h001F},   // R2 ext2 stops at bit 4
        {4'd1, 16'h00F5, 4'd1, 16'h0005},   // R2 dma0 stops at bit 3
        {4'd7, 16'h0000, 4'd7, 16'h0000},   // R3 clear all masks
        {4'd8, 16'hFFFF, 4'd8, 16'h0000}    // R13 command reads zero
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tmr_req_i = 0; dma_req_i = '0; ext_i = '0;
        bus_we_i = 0; ack_i = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_we_i = 1'b0; bus_addr_i = 4'd0;
        #2;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr_i = a;
        #2 d = bus_rdata_o;
    endtask

    task automatic pulse_int(input logic t, input logic [1:0] dm);
        @(negedge clk);
        tmr_req_i = t; dma_req_i = dm;
        @(negedge clk);
        tmr_req_i = 0; dma_req_i = '0;
        #2;
    endtask

    task automatic ack();
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        #2;
    endtask

    initial begin
        logic [15:0] v;
        do_reset();
        settle();
        // R1 reset state
        chk("R1 irq", irq_o, 0);
        chk("R1 vec", vec_o, 0);
        rd(4'd0, v); chk("R1 timer word", v, 16'h000F);
        rd(4'd3, v); chk("R1 ext0 word", v, 16'h000F);
        rd(4'd7, v); chk("R1 mask view", v, 16'h007F);

        for (int k = 0; k < 8; k++) begin
            wr(TBL[k][39:36], TBL[k][35:20]);
            rd(TBL[k][19:16], v);
            chk($sformatf("R2/R3/R13 table %0d", k), v, TBL[k][15:0]);
        end

        do_reset();
        // R4: masked timer held pending, forwarded once unmasked
        pulse_int(1'b1, 2'b00);
        settle(); chk("R4 masked quiet", irq_o, 0);
        wr(4'd0, 16'h0003);
        chk("R4 unmask forwards", irq_o, 1);
        ack();
        chk("R9 timer vector", vec_o, 8);
        chk("R9 irq drops", irq_o, 0);

        // R6: equal level blocked, higher level nests
        wr(4'd1, 16'h0003);
        pulse_int(1'b0, 2'b01);
        settle(); chk("R6 equal blocked", irq_o, 0);
        wr(4'd2, 16'h0001);
        pulse_int(1'b0, 2'b10);
        settle(); chk("R6 higher nests", irq_o, 1);
        ack(); chk("R9 dma1 vector", vec_o, 11);
        // R11 nonspecific clears dma1 (prio 1), timer still blocks dma0
        wr(4'd8, 16'h8000);
        chk("R11 ns eoi", irq_o, 0);
        wr(4'd8, 16'h0009);
        chk("R10 unknown type ignored", irq_o, 0);
        wr(4'd8, 16'h0008);
        chk("R10 timer cleared", irq_o, 1);
        ack(); chk("R10 dma0 vector", vec_o, 10);
        wr(4'd8, 16'h000A);
        chk("R10 dma0 cleared", irq_o, 0);

        // R5: tie -> lower type; lower value beats lower type
        wr(4'd1, 16'h0002); wr(4'd2, 16'h0002);
        pulse_int(1'b0, 2'b11);
        ack(); chk("R5 tie to type 10", vec_o, 10);
        wr(4'd8, 16'h8000);
        ack(); chk("R5 tie second", vec_o, 11);
        wr(4'd8, 16'h8000);
        pulse_int(1'b1, 2'b10);
        ack(); chk("R5 value beats type", vec_o, 11);
        wr(4'd8, 16'h8000);
        ack(); chk("R5 timer after", vec_o, 8);
        wr(4'd8, 16'h8000);
        chk("R11 all clear", irq_o, 0);

        // R7: level pin re-requests while high
        wr(4'd3, 16'h0010);
        @(negedge clk); ext_i[0] = 1'b1;
        #2 chk("R7 level request", irq_o, 1);
        ack(); chk("R7 vector", vec_o, 12);
        wr(4'd8, 16'h8000);
        chk("R7 re-request", irq_o, 1);
        ack();
        @(negedge clk); ext_i[0] = 1'b0;
        wr(4'd8, 16'h8000);
        chk("R7 low quiet", irq_o, 0);

        // R8: edge pin
        wr(4'd4, 16'h0000);
        @(negedge clk); ext_i[1] = 1'b1;
        #2 chk("R8 edge request", irq_o, 1);
        ack(); chk("R8 vector", vec_o, 13);
        wr(4'd8, 16'h8000);
        chk("R8 no re-arm", irq_o, 0);
        @(negedge clk); ext_i[1] = 1'b0;
        @(negedge clk); ext_i[1] = 1'b1;
        #2 chk("R8 new edge", irq_o, 1);
        @(negedge clk); ext_i[1] = 1'b0;
        #2 chk("R8 lost on fall", irq_o, 0);
        settle(); chk("R8 stays lost", irq_o, 0);

        // R12: mode bits shut off pins 2 and 3
        wr(4'd5, 16'h0010);
        @(negedge clk); ext_i[2] = 1'b1;
        #2 chk("R12 pin2 live", irq_o, 1);
        wr(4'd3, 16'h0030);
        chk("R12 cascade gates", irq_o, 0);
        wr(4'd3, 16'h0010);
        wr(4'd4, 16'h0040);
        chk("R12 nested gates", irq_o, 0);
        wr(4'd4, 16'h0000);
        chk("R12 released", irq_o, 1);
        @(negedge clk); ext_i[2] = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule